// File: doc/BRIEF.md
# Tiled Pixmap Rectangle Fill Engine

This block paints a rectangle of a framebuffer with a repeating pattern taken from a small pixmap held in its own storage. A command stream, one 32-bit word per accepted beat, first loads pixmaps with a define command and then issues draw commands that name one of them. For every destination pixel the engine works out which tile pixel lands there, reads the packed tile word and presents the pixel on a framebuffer write port.

Two draw flavours exist. A screen-anchored fill places the tile so that its origin repeats on a grid fixed to screen coordinate zero: the tile pixel equals the screen coordinate modulo the tile size. An offset copy lets the caller choose the tile coordinate that lands on the first destination pixel. That source coordinate is reduced modulo the tile size, and the walk wraps from there. Both flavours share one remainder stage and one raster walker. Commands are framed by a first-word marker and an opcode; the engine holds off new words while it draws.

Top module: `tile_fill_engine`

## Requirements
- R1: After reset `cmd_ready` is high and `fb_we`, `done` and `err` are low.
- R2: A define command (opcode 0) carries the slot number, tile width, tile height and pixel depth. It is followed by height rows of ceil(width / 4) words. Pixel i of a row sits in word i/4 of that row at bits [8*(i%4)+7 : 8*(i%4)]. A later define of the same slot replaces its contents and size.
- R3: A define whose slot is not below NUM_PIX, whose width or height is 0 or above MAX_DIM, or whose depth differs from PIX_BPP raises `err` for one cycle on the cycle after its depth word. It leaves the slot's previous contents and size in effect.
- R4: A fill command (opcode 1: slot, X, Y, width, height) writes pixel (X+i, Y+j) with tile pixel ((X+i) mod tile width, (Y+j) mod tile height).
- R5: A copy command (opcode 2: slot, source X, source Y, dest X, dest Y, width, height) writes pixel (DX+i, DY+j) with tile pixel ((SX+i) mod tile width, (SY+j) mod tile height).
- R6: A draw writes exactly width*height pixels, one per `fb_we` cycle, in row-major order. Destination coordinates wrap modulo 2^COORD_W.
- R7: `done` pulses for one cycle on the cycle after the last pixel write. A draw with zero width or zero height pulses `done` and writes nothing.
- R8: A fill or copy naming a slot not below NUM_PIX, or a slot never successfully defined, raises `err` for one cycle after its first word. It writes nothing and gives no `done`.
- R9: Words without `cmd_first` that arrive outside a command, words that trail a rejected command, and commands with opcode 3 are ignored. They change no tile storage and start no draw.
- R10: `cmd_ready` stays low from the start of a draw's setup until its last pixel has been written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command word present |
| cmd_first | input | 1 | Word is the first of a command (slot number) |
| cmd_op | input | 2 | Opcode with the first word: 0 define, 1 fill, 2 copy, 3 none |
| cmd_word | input | 32 | Command word |
| cmd_ready | output | 1 | Engine accepts a word this cycle |
| fb_we | output | 1 | Framebuffer pixel write strobe |
| fb_x | output | COORD_W | Destination column |
| fb_y | output | COORD_W | Destination row |
| fb_data | output | PIX_BPP | Pixel value |
| done | output | 1 | Draw finished pulse |
| err | output | 1 | Command rejected pulse |

## Verification
The bench builds the engine with four slots, tiles of at most 8x8 pixels, 8-bit pixels and 10-bit coordinates. The small tile limit makes width 9 an out-of-range size the bench can send. It also makes rectangles of a few dozen pixels wrap the tile several times in both axes, including a 1x1 tile that repeats every pixel. The 10-bit coordinates let a destination near column 1023 cross the coordinate wrap inside one row.

// File: rtl/tile_fill_pkg.sv
package tile_fill_pkg;

    typedef enum logic [1:0] {
        OP_DEFINE = 2'd0,
        OP_FILL   = 2'd1,
        OP_COPY   = 2'd2,
        OP_NONE   = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_CALC,
        ST_DRAW
    } state_e;

    // Geometry of one draw, latched when its last word arrives.
    typedef struct packed {
        logic [15:0] ox;   // tile-space origin before reduction
        logic [15:0] oy;
        logic [15:0] dx;   // destination origin
        logic [15:0] dy;
        logic [15:0] w;
        logic [15:0] h;
    } job_t;

    // Index of the final header word of each command kind.
    function automatic logic [2:0] last_arg(op_e op);
        case (op)
            OP_DEFINE: return 3'd3;
            OP_FILL:   return 3'd4;
            OP_COPY:   return 3'd6;
            default:   return 3'd0;
        endcase
    endfunction

    // Packed words needed for one tile row of w pixels.
    function automatic logic [31:0] row_words(logic [31:0] w, int sel_w);
        return (w + ((32'd1 << sel_w) - 32'd1)) >> sel_w;
    endfunction

endpackage

// File: rtl/tile_rem_unit.sv
module tile_rem_unit #(
    parameter int NUM_W = 12,
    parameter int DEN_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [DEN_W-1:0] rem,
    output logic             fin
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] acc;
    logic [NUM_W-1:0] shf;
    logic [CNT_W-1:0] cnt;
    logic             busy;
    logic [DEN_W:0]   trial;

    assign trial = {acc, shf[NUM_W-1]};
    assign rem   = acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            shf  <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            fin  <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (start) begin
                acc  <= '0;
                shf  <= num;
                cnt  <= CNT_W'(NUM_W);
                busy <= 1'b1;
            end else if (busy) begin
                if (trial >= {1'b0, den}) acc <= DEN_W'(trial - {1'b0, den});
                else                      acc <= trial[DEN_W-1:0];
                shf <= shf << 1;
                cnt <= cnt - CNT_W'(1);
                if (cnt == CNT_W'(1)) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tile_store.sv
module tile_store #(
    parameter int NUM_PIX = 4,
    parameter int ID_W    = 2,
    parameter int DIM_W   = 6,
    parameter int ADDR_W  = 10,
    parameter int DEPTH   = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              def_we,
    input  logic [ID_W-1:0]   def_id,
    input  logic [DIM_W-1:0]  def_w,
    input  logic [DIM_W-1:0]  def_h,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic [ID_W-1:0]   q_id,
    output logic              q_valid,
    output logic [DIM_W-1:0]  q_w,
    output logic [DIM_W-1:0]  q_h
);
    logic [31:0]      mem  [DEPTH];
    logic [NUM_PIX-1:0] slot_ok;
    logic [DIM_W-1:0] wid  [NUM_PIX];
    logic [DIM_W-1:0] hgt  [NUM_PIX];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        rd_data <= mem[rd_addr];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_ok <= '0;
            for (int i = 0; i < NUM_PIX; i++) begin
                wid[i] <= '0;
                hgt[i] <= '0;
            end
        end else if (def_we) begin
            slot_ok[def_id] <= 1'b1;
            wid[def_id]     <= def_w;
            hgt[def_id]     <= def_h;
        end
    end

    assign q_valid = slot_ok[q_id];
    assign q_w     = wid[q_id];
    assign q_h     = hgt[q_id];
endmodule

// File: rtl/tile_fill_engine.sv
module tile_fill_engine
    import tile_fill_pkg::*;
#(
    parameter int NUM_PIX = 4,
    parameter int MAX_DIM = 32,
    parameter int PIX_BPP = 8,
    parameter int COORD_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic               cmd_first,
    input  logic [1:0]         cmd_op,
    input  logic [31:0]        cmd_word,
    output logic               cmd_ready,
    output logic               fb_we,
    output logic [COORD_W-1:0] fb_x,
    output logic [COORD_W-1:0] fb_y,
    output logic [PIX_BPP-1:0] fb_data,
    output logic               done,
    output logic               err
);
    localparam int PPW    = 32 / PIX_BPP;
    localparam int SEL_W  = $clog2(PPW);
    localparam int ID_W   = $clog2(NUM_PIX);
    localparam int IDX_W  = $clog2(MAX_DIM);
    localparam int DIM_W  = IDX_W + 1;
    localparam int WCOL_W = $clog2(MAX_DIM / PPW);
    localparam int ADDR_W = ID_W + IDX_W + WCOL_W;
    localparam int DEPTH  = NUM_PIX * MAX_DIM * (MAX_DIM / PPW);

    state_e             st;
    op_e                op;
    logic [31:0]        args [8];
    logic [2:0]         widx;
    logic [ID_W-1:0]    cur_id;
    job_t               job;
    logic [IDX_W-1:0]   wrow;
    logic [WCOL_W-1:0]  wcol;
    logic [WCOL_W:0]    wpr;
    logic [DIM_W-1:0]   dh;
    logic               rem_go;
    logic [COORD_W-1:0] cx, cy;
    logic [IDX_W-1:0]   tx, ty, tx0;
    logic               pv, pl;
    logic [COORD_W-1:0] px, py;
    logic [SEL_W-1:0]   psel;

    // tile storage and remainder units
    logic               accept, first_acc, id_ok, hdr_ok, def_we, wr_en, data_last;
    logic [ID_W-1:0]    q_id;
    logic               q_valid;
    logic [DIM_W-1:0]   q_w, q_h, rem_x, rem_y;
    logic               fin_x, fin_y;
    logic [31:0]        rd_data;
    logic [ADDR_W-1:0]  wr_addr, rd_addr;
    logic [COORD_W-1:0] rw, rh;
    logic               col_end, last_px;
    logic [IDX_W-1:0]   tx_nx, ty_nx;

    assign accept    = cmd_valid && cmd_ready;
    assign first_acc = accept && cmd_first;
    assign q_id      = first_acc ? cmd_word[ID_W-1:0] : cur_id;
    assign id_ok     = (cmd_word < 32'(NUM_PIX)) && q_valid;
    assign hdr_ok    = (args[0] < 32'(NUM_PIX))
                    && (args[1] != 32'd0) && (args[1] <= 32'(MAX_DIM))
                    && (args[2] != 32'd0) && (args[2] <= 32'(MAX_DIM))
                    && (cmd_word == 32'(PIX_BPP));
    assign def_we    = accept && !cmd_first && (st == ST_HDR) && (op == OP_DEFINE)
                    && (widx == 3'd3) && hdr_ok;
    assign wr_en     = accept && !cmd_first && (st == ST_DATA);
    assign wr_addr   = {args[0][ID_W-1:0], wrow, wcol};
    assign data_last = ((32'(wrow) + 32'd1) == 32'(dh)) && ((32'(wcol) + 32'd1) == 32'(wpr));

    assign rw        = job.w[COORD_W-1:0];
    assign rh        = job.h[COORD_W-1:0];
    assign col_end   = (cx == rw - COORD_W'(1));
    assign last_px   = col_end && (cy == rh - COORD_W'(1));
    assign tx_nx     = ((DIM_W'(tx) + DIM_W'(1)) == q_w) ? '0 : tx + IDX_W'(1);
    assign ty_nx     = ((DIM_W'(ty) + DIM_W'(1)) == q_h) ? '0 : ty + IDX_W'(1);
    assign rd_addr   = {cur_id, ty, tx[IDX_W-1:SEL_W]};

    assign cmd_ready = ((st == ST_IDLE) || (st == ST_HDR) || (st == ST_DATA)) && !pv;
    assign fb_we     = pv;
    assign fb_x      = px;
    assign fb_y      = py;
    assign fb_data   = rd_data[psel*PIX_BPP +: PIX_BPP];

    tile_store #(
        .NUM_PIX(NUM_PIX), .ID_W(ID_W), .DIM_W(DIM_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)
    ) store_i (
        .clk(clk), .rst(rst),
        .def_we(def_we), .def_id(args[0][ID_W-1:0]),
        .def_w(args[1][DIM_W-1:0]), .def_h(args[2][DIM_W-1:0]),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(cmd_word),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .q_id(q_id), .q_valid(q_valid), .q_w(q_w), .q_h(q_h)
    );

    tile_rem_unit #(.NUM_W(COORD_W), .DEN_W(DIM_W)) rem_x_i (
        .clk(clk), .rst(rst), .start(rem_go), .num(job.ox[COORD_W-1:0]),
        .den(q_w), .rem(rem_x), .fin(fin_x)
    );

    tile_rem_unit #(.NUM_W(COORD_W), .DEN_W(DIM_W)) rem_y_i (
        .clk(clk), .rst(rst), .start(rem_go), .num(job.oy[COORD_W-1:0]),
        .den(q_h), .rem(rem_y), .fin(fin_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            op     <= OP_NONE;
            widx   <= '0;
            cur_id <= '0;
            job    <= '0;
            wrow   <= '0;
            wcol   <= '0;
            wpr    <= '0;
            dh     <= '0;
            rem_go <= 1'b0;
            err    <= 1'b0;
            done   <= 1'b0;
            cx     <= '0;
            cy     <= '0;
            tx     <= '0;
            ty     <= '0;
            tx0    <= '0;
            pv     <= 1'b0;
            pl     <= 1'b0;
            px     <= '0;
            py     <= '0;
            psel   <= '0;
            for (int i = 0; i < 8; i++) args[i] <= '0;
        end else begin
            err    <= 1'b0;
            rem_go <= 1'b0;
            done   <= pv && pl;
            pv     <= 1'b0;
            pl     <= 1'b0;
            if (first_acc) begin
                op      <= op_e'(cmd_op);
                args[0] <= cmd_word;
                cur_id  <= cmd_word[ID_W-1:0];
                widx    <= 3'd1;
                if (op_e'(cmd_op) == OP_NONE) begin
                    st <= ST_IDLE;
                end else if (op_e'(cmd_op) != OP_DEFINE && !id_ok) begin
                    err <= 1'b1;
                    st  <= ST_IDLE;
                end else begin
                    st <= ST_HDR;
                end
            end else if (accept && st == ST_HDR) begin
                args[widx] <= cmd_word;
                widx       <= widx + 3'd1;
                if (widx == last_arg(op)) begin
                    case (op)
                        OP_DEFINE: begin
                            if (hdr_ok) begin
                                st   <= ST_DATA;
                                wrow <= '0;
                                wcol <= '0;
                                wpr  <= (WCOL_W+1)'(row_words(args[1], SEL_W));
                                dh   <= args[2][DIM_W-1:0];
                            end else begin
                                err <= 1'b1;
                                st  <= ST_IDLE;
                            end
                        end
                        OP_FILL: begin
                            job    <= '{ox: args[1][15:0], oy: args[2][15:0],
                                        dx: args[1][15:0], dy: args[2][15:0],
                                        w:  args[3][15:0], h:  cmd_word[15:0]};
                            rem_go <= 1'b1;
                            st     <= ST_CALC;
                        end
                        OP_COPY: begin
                            job    <= '{ox: args[1][15:0], oy: args[2][15:0],
                                        dx: args[3][15:0], dy: args[4][15:0],
                                        w:  args[5][15:0], h:  cmd_word[15:0]};
                            rem_go <= 1'b1;
                            st     <= ST_CALC;
                        end
                        default: st <= ST_IDLE;
                    endcase
                end
            end else if (accept && st == ST_DATA) begin
                if (data_last) begin
                    st <= ST_IDLE;
                end else if ((32'(wcol) + 32'd1) == 32'(wpr)) begin
                    wcol <= '0;
                    wrow <= wrow + IDX_W'(1);
                end else begin
                    wcol <= wcol + WCOL_W'(1);
                end
            end else if (st == ST_CALC && fin_x && fin_y) begin
                if (rw == '0 || rh == '0) begin
                    done <= 1'b1;
                    st   <= ST_IDLE;
                end else begin
                    tx  <= rem_x[IDX_W-1:0];
                    tx0 <= rem_x[IDX_W-1:0];
                    ty  <= rem_y[IDX_W-1:0];
                    cx  <= '0;
                    cy  <= '0;
                    st  <= ST_DRAW;
                end
            end else if (st == ST_DRAW) begin
                pv   <= 1'b1;
                pl   <= last_px;
                px   <= job.dx[COORD_W-1:0] + cx;
                py   <= job.dy[COORD_W-1:0] + cy;
                psel <= tx[SEL_W-1:0];
                if (col_end) begin
                    cx <= '0;
                    cy <= cy + COORD_W'(1);
                    tx <= tx0;
                    ty <= ty_nx;
                    if (last_px) st <= ST_IDLE;
                end else begin
                    cx <= cx + COORD_W'(1);
                    tx <= tx_nx;
                end
            end
        end
    end
endmodule

// File: rtl/tile_fill_engine_chk.sv
module tile_fill_engine_chk #(
    parameter int COORD_W = 12
) (
    input logic               clk,
    input logic               rst,
    input logic               cmd_ready,
    input logic               fb_we,
    input logic [COORD_W-1:0] fb_x,
    input logic [COORD_W-1:0] fb_y,
    input logic               done,
    input logic               err
);
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        rst |=> (!fb_we && !done && !err && cmd_ready));

    a_r6_row_major_step: assert property (@(posedge clk) disable iff (rst)
        (fb_we && $past(fb_we) && fb_y == $past(fb_y))
            |-> fb_x == COORD_W'($past(fb_x) + COORD_W'(1)));

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_err_without_write: assert property (@(posedge clk) disable iff (rst)
        err |-> !fb_we);

    a_r8_err_excl_done: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, err}));

    a_r10_no_ready_while_writing: assert property (@(posedge clk) disable iff (rst)
        fb_we |-> !cmd_ready);
endmodule

bind tile_fill_engine tile_fill_engine_chk #(.COORD_W(COORD_W)) chk_i (
    .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .fb_we(fb_we),
    .fb_x(fb_x), .fb_y(fb_y), .done(done), .err(err)
);

// File: tb/tile_fill_engine_tb_top.sv
module tile_fill_engine_tb_top;
    localparam int NP = 4;
    localparam int MD = 8;
    localparam int CW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0, cmd_first = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic [31:0]   cmd_word = '0;
    logic          cmd_ready, fb_we, done, err;
    logic [CW-1:0] fb_x, fb_y;
    logic [7:0]    fb_data;

    always #4 clk = ~clk;

    tile_fill_engine #(.NUM_PIX(NP), .MAX_DIM(MD), .PIX_BPP(8), .COORD_W(CW)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_first(cmd_first),
        .cmd_op(cmd_op), .cmd_word(cmd_word), .cmd_ready(cmd_ready),
        .fb_we(fb_we), .fb_x(fb_x), .fb_y(fb_y), .fb_data(fb_data),
        .done(done), .err(err)
    );

    int n_chk = 0, n_bad = 0;
    int cyc = 0, last_we = -10;
    int done_n = 0, err_n = 0, got_n = 0, exp_n = 0;
    int exp_x [512], exp_y [512], exp_d [512];
    logic [7:0] tpix [NP][MD][MD];
    int tw [NP], th [NP];
    bit tdef [NP];
    bit finished = 1'b0;

    typedef struct packed {
        logic [1:0] op;
        logic [7:0] id;
        logic [9:0] sx, sy, dx, dy, w, h;
    } vec_t;

    // op, slot, sx, sy, dx, dy, w, h
    localparam vec_t VEC [8] = '{
        '{2'd1, 8'd0, 10'd0,  10'd0, 10'd7,    10'd4,  10'd6, 10'd5},
        '{2'd1, 8'd1, 10'd0,  10'd0, 10'd0,    10'd0,  10'd8, 10'd2},
        '{2'd2, 8'd0, 10'd12, 10'd2, 10'd100,  10'd50, 10'd7, 10'd4},
        '{2'd2, 8'd3, 10'd2,  10'd9, 10'd1020, 10'd3,  10'd6, 10'd3},
        '{2'd1, 8'd2, 10'd0,  10'd0, 10'd33,   10'd77, 10'd4, 10'd4},
        '{2'd2, 8'd1, 10'd7,  10'd7, 10'd3,    10'd3,  10'd3, 10'd3},
        '{2'd1, 8'd3, 10'd0,  10'd0, 10'd9,    10'd9,  10'd0, 10'd5},
        '{2'd2, 8'd0, 10'd1,  10'd1, 10'd2,    10'd2,  10'd4, 10'd0}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic send(input bit first, input int op, input int word);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_first = first;
        cmd_op    = 2'(op);
        cmd_word  = 32'(word);
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        #1 cmd_valid = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (fb_we) begin
                if (got_n < exp_n) begin
                    chk(fb_x == CW'(exp_x[got_n]), "R6 write column", int'(fb_x), exp_x[got_n]);
                    chk(fb_y == CW'(exp_y[got_n]), "R6 write row", int'(fb_y), exp_y[got_n]);
                    chk(fb_data == 8'(exp_d[got_n]), "R4/R5 pixel value", int'(fb_data), exp_d[got_n]);
                end else begin
                    chk(1'b0, "R6 surplus write", got_n + 1, exp_n);
                end
                chk(!cmd_ready, "R10 ready low while drawing", int'(cmd_ready), 0);
                got_n++;
                last_we = cyc;
            end
            if (done) begin
                done_n++;
                if (exp_n > 0) chk(cyc == last_we + 1, "R7 done after last write", cyc, last_we + 1);
            end
            if (err) err_n++;
        end
    end

    task automatic do_define(input int id, input int w, input int h, input int depth,
                             input int seed, input string tag);
        bit ok;
        int e0;
        ok = (id < NP) && (w >= 1) && (w <= MD) && (h >= 1) && (h <= MD) && (depth == 8);
        e0 = err_n;
        send(1'b1, 0, id);
        send(1'b0, 0, w);
        send(1'b0, 0, h);
        send(1'b0, 0, depth);
        if (ok) begin
            tdef[id] = 1'b1;
            tw[id] = w;
            th[id] = h;
            for (int y = 0; y < h; y++) begin
                for (int x = 0; x < w; x++) tpix[id][y][x] = 8'((id * 37 + y * 11 + x * 5 + seed) & 255);
                for (int j = 0; j < (w + 3) / 4; j++) begin
                    int word = 0;
                    for (int b = 0; b < 4; b++)
                        if (4 * j + b < w) word |= int'(tpix[id][y][4 * j + b]) << (8 * b);
                    send(1'b0, 0, word);
                end
            end
        end
        repeat (3) @(negedge clk);
        chk(err_n - e0 == (ok ? 0 : 1), tag, err_n - e0, ok ? 0 : 1);
    endtask

    task automatic do_draw(input int op, input int id, input int sx, input int sy,
                           input int dx, input int dy, input int w, input int h,
                           input string tag);
        bit ok;
        int d0, e0, ox, oy, t;
        ok = (id < NP) && tdef[id];
        exp_n = 0;
        got_n = 0;
        ox = (op == 1) ? dx : sx;
        oy = (op == 1) ? dy : sy;
        if (ok) begin
            for (int j = 0; j < h; j++)
                for (int i = 0; i < w; i++) begin
                    exp_x[exp_n] = (dx + i) % (1 << CW);
                    exp_y[exp_n] = (dy + j) % (1 << CW);
                    exp_d[exp_n] = int'(tpix[id][(oy + j) % th[id]][(ox + i) % tw[id]]);
                    exp_n++;
                end
        end
        d0 = done_n;
        e0 = err_n;
        send(1'b1, op, id);
        if (op == 1) begin
            send(1'b0, 0, dx); send(1'b0, 0, dy);
        end else begin
            send(1'b0, 0, sx); send(1'b0, 0, sy);
            send(1'b0, 0, dx); send(1'b0, 0, dy);
        end
        send(1'b0, 0, w);
        send(1'b0, 0, h);
        t = 0;
        while (done_n == d0 && err_n == e0 && t < 4000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
        chk(got_n == exp_n, {tag, " R6 write count"}, got_n, exp_n);
        chk(done_n - d0 == (ok ? 1 : 0), {tag, " R7 done count"}, done_n - d0, ok ? 1 : 0);
        chk(err_n - e0 == (ok ? 0 : 1), {tag, " R8 err count"}, err_n - e0, ok ? 0 : 1);
    endtask

    initial begin
        for (int i = 0; i < NP; i++) begin
            tdef[i] = 1'b0;
            tw[i] = 1;
            th[i] = 1;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R1 ready after reset", int'(cmd_ready), 1);
        chk(fb_we == 1'b0, "R1 no write after reset", int'(fb_we), 0);
        chk(!done && !err, "R1 no pulses after reset", int'({done, err}), 0);

        do_draw(1, 3, 0, 0, 2, 2, 3, 3, "R8 undefined slot");

        do_define(0, 5, 3, 8, 0, "R2 define slot 0");
        do_define(1, 8, 8, 8, 1, "R2 define slot 1");
        do_define(2, 1, 1, 8, 2, "R2 define slot 2");
        do_define(3, 3, 7, 8, 3, "R2 define slot 3");

        for (int k = 0; k < 8; k++)
            do_draw(int'(VEC[k].op), int'(VEC[k].id), int'(VEC[k].sx), int'(VEC[k].sy),
                    int'(VEC[k].dx), int'(VEC[k].dy), int'(VEC[k].w), int'(VEC[k].h),
                    (VEC[k].op == 2'd1) ? "R4 table fill" : "R5 table copy");

        do_draw(1, 4, 0, 0, 1, 1, 2, 2, "R8 slot out of range");

        do_define(0, 9, 2, 8, 5, "R3 width too large");
        do_define(5, 2, 2, 8, 5, "R3 slot out of range");
        do_define(1, 3, 0, 8, 5, "R3 zero height");
        do_define(2, 2, 2, 16, 5, "R3 depth mismatch");
        do_draw(1, 0, 0, 0, 7, 4, 6, 5, "R3 slot 0 kept");
        do_draw(1, 2, 0, 0, 4, 4, 2, 2, "R3 slot 2 kept");

        begin
            int e0;
            e0 = err_n;
            send(1'b0, 0, 32'h1234);
            send(1'b0, 0, 7);
            send(1'b1, 3, 0);
            send(1'b0, 0, 99);
            repeat (4) @(negedge clk);
            chk(err_n == e0, "R9 stray words raise nothing", err_n - e0, 0);
            chk(got_n == exp_n, "R9 stray words draw nothing", got_n, exp_n);
        end
        do_draw(2, 1, 3, 5, 20, 30, 5, 4, "R9 copy after stray words");

        do_define(2, 2, 2, 8, 9, "R2 redefine slot 2");
        do_draw(1, 2, 0, 0, 5, 5, 4, 3, "R2 fill redefined slot");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule